// File: doc/BRIEF.md
# Wiper Position Register with Tap Decoder

This block holds the 6-bit setting of one digitally controlled potentiometer wiper. It also drives a registered one-hot bus of 64 tap-select lines. Exactly one line is high at any moment, and it is the line whose index equals the stored position. A surrounding serial command decoder changes the position in four ways:

- A power-up restore copies data register 0 into the position.
- A transfer copies any one of the four data registers into the position.
- A host write takes the low six bits of a received byte.
- A single-step request moves the wiper by one tap. The direction follows the serial input level sampled on that clock pulse.

The current position is always visible on an output, so it can be read back or copied into a data register.

When several requests arrive in the same cycle, a fixed priority decides which one applies. Stepping saturates at both ends of the range and does not wrap. All changes take effect on the rising clock edge after the request. The position output and the tap bus change on the same edge.

Top module: `wiper_ctr_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the position becomes 0 and only tap line 0 is active.
- R2: `tap_sel` always has exactly one bit set, at the index equal to `pos`. Both outputs change on the same clock edge.
- R3: A `pwr_load` pulse loads data register 0 into the position. Register 0 is `dr_bank[5:0]`.
- R4: An `xfer_en` pulse loads data register `xfer_sel` into the position. Register i occupies `dr_bank[6*i+5:6*i]`.
- R5: A `host_wr` pulse loads `host_byte[5:0]` into the position. Bits 7 and 6 of the byte are ignored.
- R6: A `step_en` pulse with `step_up` high adds one to the position. At 63 the position stays at 63.
- R7: A `step_en` pulse with `step_up` low subtracts one from the position. At 0 the position stays at 0.
- R8: When requests arrive in the same cycle, the order of precedence is `pwr_load`, then `xfer_en`, then `host_wr`, then `step_en`.
- R9: In a cycle with no request, the position and the tap bus keep their values, whatever `step_up`, `xfer_sel`, `host_byte` or `dr_bank` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_load | input | 1 | Power-up restore request (load register 0) |
| xfer_en | input | 1 | Transfer request from the selected data register |
| xfer_sel | input | 2 | Data register index for a transfer |
| dr_bank | input | 24 | Four 6-bit data register values, register i at bits 6i+5:6i |
| host_wr | input | 1 | Host write request |
| host_byte | input | 8 | Host data byte; only bits 5:0 are used |
| step_en | input | 1 | One-tap step request, one cycle per serial clock pulse |
| step_up | input | 1 | Step direction: 1 toward the high terminal, 0 toward the low terminal |
| pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | Registered one-hot tap select |

## Verification
The assertions assume that every request is a single-cycle strobe that is already synchronous to `clk`. This means one `step_en` pulse per serial clock pulse, with `step_up` valid in that same cycle. They also assume that `dr_bank` and `host_byte` are steady at the clock edge where they are sampled. The bench meets these assumptions by changing every input on the falling edge and dropping each strobe after exactly one rising edge. It then reads `pos` and `tap_sel` on the next falling edge.

// File: rtl/wcr_pkg.sv
// Package: shared definitions for the wiper position register.
// Assumes: nothing; type definitions only.
package wcr_pkg;
    // Identifies which request updated the position in a cycle.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_PWR  = 3'd1,
        SRC_XFER = 3'd2,
        SRC_HOST = 3'd3,
        SRC_STEP = 3'd4
    } wcr_src_e;
endpackage

// File: rtl/wcr_stepper.sv
// Module: saturating one-tap step of the wiper position.
// Assumes: cur holds a valid position; the result never wraps.
module wcr_stepper #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] cur,
    input  logic             up,
    output logic [POS_W-1:0] val
);
    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    // Next position one tap up or down, held at either end.
    always_comb begin
        if (up) begin
            val = (cur == TOP) ? cur : cur + 1'b1;
        end else begin
            val = (cur == '0) ? cur : cur - 1'b1;
        end
    end
endmodule

// File: rtl/wcr_src_mux.sv
// Module: prioritised selection of the next wiper position.
// Assumes: requests are single-cycle strobes; dr_bank packs N_DR
//          entries of POS_W bits, entry i at bits [i*POS_W +: POS_W].
module wcr_src_mux
    import wcr_pkg::*;
#(
    parameter int POS_W  = 6,
    parameter int N_DR   = 4,
    parameter int BYTE_W = 8,
    localparam int SEL_W = (N_DR > 1) ? $clog2(N_DR) : 1
) (
    input  logic                    pwr_load,
    input  logic                    xfer_en,
    input  logic [SEL_W-1:0]        xfer_sel,
    input  logic [N_DR*POS_W-1:0]   dr_bank,
    input  logic                    host_wr,
    input  logic [BYTE_W-1:0]       host_byte,
    input  logic                    step_en,
    input  logic [POS_W-1:0]        step_val,
    output logic [POS_W-1:0]        nxt,
    output logic                    load,
    output wcr_src_e                src
);
    logic [POS_W-1:0] dr_ent [N_DR];

    // Unpack the flat register bank into one entry per register.
    for (genvar i = 0; i < N_DR; i++) begin : g_unpack
        assign dr_ent[i] = dr_bank[i*POS_W +: POS_W];
    end

    // Choose the winning request: restore, transfer, host write, step.
    always_comb begin
        nxt  = step_val;
        load = 1'b1;
        src  = SRC_STEP;
        if (pwr_load) begin
            nxt = dr_ent[0];
            src = SRC_PWR;
        end else if (xfer_en) begin
            nxt = dr_ent[xfer_sel];
            src = SRC_XFER;
        end else if (host_wr) begin
            nxt = host_byte[POS_W-1:0];
            src = SRC_HOST;
        end else if (!step_en) begin
            load = 1'b0;
            src  = SRC_NONE;
        end
    end
endmodule

// File: rtl/wcr_tap_decoder.sv
// Module: registered one-hot decode of the wiper position.
// Assumes: nxt is the value the position register takes on the same edge,
//          so the taps and the position never disagree.
module wcr_tap_decoder #(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [POS_W-1:0] nxt,
    output logic [TAPS-1:0]  tap_sel
);
    // One flop per tap line; only the line matching the position is set.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tap_sel[t] <= (t == 0);
            end else if (load) begin
                tap_sel[t] <= (nxt == POS_W'(t));
            end
        end
    end
endmodule

// File: rtl/wiper_ctr_reg.sv
// Module: volatile wiper position register with tap decoder (top).
// Assumes: requests are synchronous single-cycle strobes; one step_en
//          pulse per serial clock pulse, with step_up valid in that cycle.
module wiper_ctr_reg
    import wcr_pkg::*;
#(
    parameter int POS_W  = 6,
    parameter int N_DR   = 4,
    parameter int BYTE_W = 8,
    localparam int SEL_W = (N_DR > 1) ? $clog2(N_DR) : 1,
    localparam int TAPS  = 1 << POS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_load,
    input  logic                  xfer_en,
    input  logic [SEL_W-1:0]      xfer_sel,
    input  logic [N_DR*POS_W-1:0] dr_bank,
    input  logic                  host_wr,
    input  logic [BYTE_W-1:0]     host_byte,
    input  logic                  step_en,
    input  logic                  step_up,
    output logic [POS_W-1:0]      pos,
    output logic [TAPS-1:0]       tap_sel
);
    logic [POS_W-1:0] step_val;
    logic [POS_W-1:0] nxt;
    logic             load;
    wcr_src_e         src;

    wcr_stepper #(.POS_W(POS_W)) u_step (
        .cur (pos),
        .up  (step_up),
        .val (step_val)
    );

    wcr_src_mux #(.POS_W(POS_W), .N_DR(N_DR), .BYTE_W(BYTE_W)) u_mux (
        .pwr_load  (pwr_load),
        .xfer_en   (xfer_en),
        .xfer_sel  (xfer_sel),
        .dr_bank   (dr_bank),
        .host_wr   (host_wr),
        .host_byte (host_byte),
        .step_en   (step_en),
        .step_val  (step_val),
        .nxt       (nxt),
        .load      (load),
        .src       (src)
    );

    // Position register: cleared by reset, updated by the winning request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (load) begin
            pos <= nxt;
        end
    end

    wcr_tap_decoder #(.POS_W(POS_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .nxt     (nxt),
        .tap_sel (tap_sel)
    );
endmodule

// File: rtl/wcr_checker.sv
// Module: assertion checker for wiper_ctr_reg, attached with bind.
// Assumes: same parameters as the bound instance.
module wcr_checker #(
    parameter int POS_W  = 6,
    parameter int N_DR   = 4,
    parameter int BYTE_W = 8,
    localparam int SEL_W = (N_DR > 1) ? $clog2(N_DR) : 1,
    localparam int TAPS  = 1 << POS_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pwr_load,
    input logic                  xfer_en,
    input logic [SEL_W-1:0]      xfer_sel,
    input logic [N_DR*POS_W-1:0] dr_bank,
    input logic                  host_wr,
    input logic [BYTE_W-1:0]     host_byte,
    input logic                  step_en,
    input logic                  step_up,
    input logic [POS_W-1:0]      pos,
    input logic [TAPS-1:0]       tap_sel
);
    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    logic only_step;
    logic idle;
    assign only_step = step_en && !pwr_load && !xfer_en && !host_wr;
    assign idle      = !step_en && !pwr_load && !xfer_en && !host_wr;

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1); // R2
    AST_TAP_AT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel[pos]); // R2
    AST_PWR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_load |=> pos == $past(dr_bank[POS_W-1:0])); // R3
    AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !pwr_load) |=> pos == $past(dr_bank[xfer_sel*POS_W +: POS_W])); // R4
    AST_HOST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !xfer_en && !pwr_load) |=> pos == $past(host_byte[POS_W-1:0])); // R5
    AST_STEP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (only_step && step_up && pos == TOP) |=> pos == TOP); // R6
    AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (only_step && !step_up && pos == '0) |=> pos == '0); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(pos) && $stable(tap_sel)); // R9
endmodule

bind wiper_ctr_reg wcr_checker #(.POS_W(POS_W), .N_DR(N_DR), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_load  (pwr_load),
    .xfer_en   (xfer_en),
    .xfer_sel  (xfer_sel),
    .dr_bank   (dr_bank),
    .host_wr   (host_wr),
    .host_byte (host_byte),
    .step_en   (step_en),
    .step_up   (step_up),
    .pos       (pos),
    .tap_sel   (tap_sel)
);

// File: tb/sim_wiper_ctr_reg.sv
// Bench: directed tests for wiper_ctr_reg, one task per scenario.
module sim_wiper_ctr_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_load = 1'b0;
    logic        xfer_en = 1'b0;
    logic [1:0]  xfer_sel = 2'd0;
    logic [23:0] dr_bank;
    logic        host_wr = 1'b0;
    logic [7:0]  host_byte = 8'd0;
    logic        step_en = 1'b0;
    logic        step_up = 1'b0;
    logic [5:0]  pos;
    logic [63:0] tap_sel;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [5:0] drv [4];
    assign dr_bank = {drv[3], drv[2], drv[1], drv[0]};

    wiper_ctr_reg u0 (
        .clk(clk), .rst_n(rst_n), .pwr_load(pwr_load), .xfer_en(xfer_en),
        .xfer_sel(xfer_sel), .dr_bank(dr_bank), .host_wr(host_wr),
        .host_byte(host_byte), .step_en(step_en), .step_up(step_up),
        .pos(pos), .tap_sel(tap_sel)
    );

    always #5 clk = ~clk;

    // Compare position and the tap bus with the expected position.
    task automatic check(input string tag, input logic [5:0] exp);
        n_run++;
        if (pos !== exp) begin
            n_fail++;
            $display("FAIL %s pos actual=%0d expected=%0d", tag, pos, exp);
        end
        n_run++;
        if (tap_sel !== (64'd1 << exp)) begin
            n_fail++;
            $display("FAIL R2 tap_sel actual=%h expected=%h", tap_sel, 64'd1 << exp);
        end
    endtask

    // Let one rising edge pass, then drop all strobes (inputs set on falling edge).
    task automatic tick();
        @(negedge clk);
        pwr_load = 1'b0; xfer_en = 1'b0; host_wr = 1'b0; step_en = 1'b0;
    endtask

    task automatic host_load(input logic [7:0] b);
        host_wr = 1'b1; host_byte = b; tick();
    endtask

    task automatic step(input logic up);
        step_en = 1'b1; step_up = up; tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        host_load(8'd9);
        check("R1 reset", 6'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_pwr();
        host_load(8'd50);
        pwr_load = 1'b1; tick();
        check("R3 power-up restore", drv[0]);
    endtask

    task automatic t_xfer();
        for (int i = 0; i < 4; i++) begin
            xfer_en = 1'b1; xfer_sel = 2'(i); tick();
            check("R4 transfer", drv[i]);
        end
    endtask

    task automatic t_host();
        host_load(8'hFF); check("R5 host 0xFF", 6'd63);
        host_load(8'hC5); check("R5 host 0xC5", 6'd5);
        host_load(8'h80); check("R5 host 0x80", 6'd0);
    endtask

    task automatic t_step_up();
        host_load(8'd61);
        step(1'b1); check("R6 step up", 6'd62);
        step(1'b1); check("R6 step up", 6'd63);
        step(1'b1); check("R6 ceiling", 6'd63);
    endtask

    task automatic t_step_dn();
        host_load(8'd2);
        step(1'b0); check("R7 step down", 6'd1);
        step(1'b0); check("R7 step down", 6'd0);
        step(1'b0); check("R7 floor", 6'd0);
    endtask

    task automatic t_prio();
        host_load(8'd30);
        pwr_load = 1'b1; xfer_en = 1'b1; xfer_sel = 2'd1; host_wr = 1'b1;
        host_byte = 8'd7; step_en = 1'b1; step_up = 1'b1; tick();
        check("R8 restore wins", drv[0]);
        xfer_en = 1'b1; xfer_sel = 2'd2; host_wr = 1'b1; host_byte = 8'd7;
        step_en = 1'b1; step_up = 1'b0; tick();
        check("R8 transfer wins", drv[2]);
        host_wr = 1'b1; host_byte = 8'd7; step_en = 1'b1; step_up = 1'b1; tick();
        check("R8 host wins", 6'd7);
    endtask

    task automatic t_hold();
        host_load(8'd21);
        step_up = 1'b1; xfer_sel = 2'd3; host_byte = 8'd44; drv[0] = 6'd3;
        tick(); check("R9 idle hold", 6'd21);
        step_up = 1'b0; drv[3] = 6'd12;
        tick(); check("R9 idle hold", 6'd21);
    endtask

    initial begin
        drv[0] = 6'd17; drv[1] = 6'd42; drv[2] = 6'd63; drv[3] = 6'd0;
        repeat (2) @(negedge clk);
        t_reset();
        t_pwr();
        t_xfer();
        t_host();
        t_step_up();
        t_step_dn();
        t_prio();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule